// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Hourly Drift Correction

This core keeps wall-clock time as six BCD fields: seconds, minutes, hours, day of month, month and a two-digit year covering 2000 to 2099. A tick-enable input, nominally pulsed at 32768 Hz, advances a sub-second prescaler. Each time the prescaler runs out, the seconds field advances, and the carry ripples through the calendar. February has 29 days in years divisible by four.

A host reaches the core over a plain strobe interface. Reads of the time fields return a shadow copy. That copy is refreshed only when the host requests a snapshot, so a read of all six fields cannot be torn by a carry between byte reads. A run bit freezes the counters while the host loads a new time.

A set of six alarm fields is compared against the live time. When all six fields come to match, the core sets a sticky status flag, which software clears by writing a one to it. An enable bit routes this flag to an active-low level interrupt. Once per hour the core can lengthen or shorten one second by a signed 16-bit tick count to cancel crystal drift.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads as year 00, month 01, day 01, 00:00:00. The control register reads 0x00, meaning stopped with correction off. `irq_n` is high and the status register reads 0x00.
- R2: Register map, all fields BCD:
  - Live and shadow time sit at 0x00 to 0x05, in the order seconds, minutes, hours, day, month, year.
  - Alarm fields sit at 0x08 to 0x0D in the same order.
  - Control is at 0x10: bit0 RUN, bit1 SNAP, bit2 AUTOCORR. SNAP always reads 0.
  - Status is at 0x11 (bit0 alarm flag) and interrupt enable is at 0x12 (bit0).
  - The correction value has its low byte at 0x14 and its high byte at 0x15.
  - `rdata` is valid in the cycle after the `rd_en` strobe.
- R3: While RUN is 0, tick pulses have no effect on the time.
- R4: With RUN at 1, the seconds field advances after every TICKS_PER_SEC tick pulses. Any write to the seconds register restarts the prescaler with a full period.
- R5: The calendar rolls over as follows:
  - Seconds 59 and minutes 59 wrap to 00 and carry.
  - Hours 23 wraps to 00 and carries.
  - The day wraps to 01 after the month's last day: 28, or 29 when the year is divisible by 4, for month 02; 30 for months 04, 06, 09 and 11; 31 otherwise.
  - Month 12 wraps to 01, and year 99 wraps to 00.
- R6: Writing 1 to SNAP copies the live time into the shadow registers. Reads of 0x00 to 0x05 return the shadow, not the live counters.
- R7: A low-byte correction write is only staged. A high-byte write commits {high, staged low} as the new correction value, unless that value is 0x7FFF, in which case it is ignored. Reads of 0x14 and 0x15 return the committed value.
- R8: With AUTOCORR set, when seconds step from 00 to 01 while minutes are 00, the next second lasts TICKS_PER_SEC minus the signed correction value in ticks (at least 1). All other seconds last TICKS_PER_SEC.
- R9: Status bit0 sets when the six live fields become equal to the six alarm fields.
- R10: Writing status with bit0 = 1 clears the flag. Writing bit0 = 0 leaves it set.
- R11: `irq_n` is low exactly when the status flag and interrupt-enable bit0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle prescaler tick (nominal 32768 Hz) |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low alarm interrupt level |

## Verification
Prescaler errors show up as the seconds field stepping one tick early or late. The bench therefore drives exact tick counts and checks both sides of each boundary, including the single lengthened or shortened second after the hourly correction point.

Calendar carry errors stay hidden until a rollover, so the bench loads the last second of a day, month, leap and non-leap February, and century, then reads the result one second later.

A wrong alarm comparison or flag state reaches `irq_n` within two cycles of the matching second. A stale shadow is visible on the very next time-register read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] hrs;
    logic [7:0] mins;
    logic [7:0] secs;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{yr: 8'h00, mon: 8'h01, mday: 8'h01,
                                          hrs: 8'h00, mins: 8'h00, secs: 8'h00};

  localparam int NUM_FIELDS = 6;

  localparam logic [4:0] A_CTRL   = 5'h10;
  localparam logic [4:0] A_STATUS = 5'h11;
  localparam logic [4:0] A_IRQEN  = 5'h12;
  localparam logic [4:0] A_CORR_L = 5'h14;
  localparam logic [4:0] A_CORR_H = 5'h15;

  localparam logic [15:0] CORR_FORBIDDEN = 16'h7FFF;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [6:0] y;
    y = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (y[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance_second(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.secs != 8'h59) begin
      n.secs = bcd_inc(t.secs);
    end else begin
      n.secs = 8'h00;
      if (t.mins != 8'h59) begin
        n.mins = bcd_inc(t.mins);
      end else begin
        n.mins = 8'h00;
        if (t.hrs != 8'h23) begin
          n.hrs = bcd_inc(t.hrs);
        end else begin
          n.hrs = 8'h00;
          if (t.mday != month_last_day(t.mon, t.yr)) begin
            n.mday = bcd_inc(t.mday);
          end else begin
            n.mday = 8'h01;
            if (t.mon != 8'h12) begin
              n.mon = bcd_inc(t.mon);
            end else begin
              n.mon = 8'h01;
              n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      3'd0:    return t.secs;
      3'd1:    return t.mins;
      3'd2:    return t.hrs;
      3'd3:    return t.mday;
      3'd4:    return t.mon;
      3'd5:    return t.yr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t set_field(input rtc_time_t t, input logic [2:0] idx,
                                          input logic [7:0] v);
    rtc_time_t n;
    n = t;
    case (idx)
      3'd0:    n.secs = v;
      3'd1:    n.mins = v;
      3'd2:    n.hrs  = v;
      3'd3:    n.mday = v;
      3'd4:    n.mon  = v;
      3'd5:    n.yr   = v;
      default: n = t;
    endcase
    return n;
  endfunction

  // Length in ticks of the second that follows the hourly correction point.
  function automatic int corrected_period(input int ticks, input logic [15:0] corr);
    int p;
    p = ticks - int'($signed(corr));
    if (p < 1) p = 1;
    return p;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             sec_evt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  assign sec_evt_o = run_i && tick_i && !restart_i && (remain_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= FULL;
    end else if (restart_i) begin
      remain_q <= FULL;
    end else if (run_i && tick_i) begin
      if (remain_q == LAST) remain_q <= reload_i;
      else                  remain_q <= remain_q - LAST;
    end
  end

  // R4: a seconds write starts a whole new period
  assert_restart_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (remain_q == FULL));

  // R8: the period chosen at a second boundary is the one loaded
  assert_reload_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt_o |=> (remain_q == $past(reload_i)));

  // R3: without run, the prescaler holds
  assert_prescaler_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(remain_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_evt_i,
  input  logic       wr_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] wdata_i,
  output rtc_time_t  now_o
);

  rtc_time_t now_q;
  rtc_time_t now_d;

  always_comb begin
    now_d = now_q;
    if (wr_i)           now_d = set_field(now_q, idx_i, wdata_i);
    else if (sec_evt_i) now_d = advance_second(now_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= TIME_AT_RESET;
    else        now_q <= now_d;
  end

  assign now_o = now_q;

  // R5: seconds wrap and carry into minutes
  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i && !wr_i && now_q.secs == 8'h59)
      |=> (now_q.secs == 8'h00 && now_q.mins != $past(now_q.mins)));

  // R5: end-of-day at month end returns day to 01
  assert_day_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i && !wr_i && now_q.secs == 8'h59 && now_q.mins == 8'h59 &&
     now_q.hrs == 8'h23 && now_q.mday == month_last_day(now_q.mon, now_q.yr))
      |=> (now_q.mday == 8'h01 && now_q.hrs == 8'h00));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtc_time_t  now_i,
  input  logic       wr_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  input  logic       irq_en_i,
  output rtc_time_t  alarm_o,
  output logic       match_rise_o,
  output logic       flag_o,
  output logic       irq_n_o
);

  rtc_time_t alarm_q;
  logic      match_now;
  logic      match_q;
  logic      flag_q;

  assign match_now    = (now_i == alarm_q);
  assign match_rise_o = match_now && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= TIME_AT_RESET;
      match_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (wr_i) alarm_q <= set_field(alarm_q, idx_i, wdata_i);
      match_q <= match_now;
      if (match_rise_o) flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;
  assign irq_n_o = !(flag_q && irq_en_i);

  // R9: a fresh match always raises the flag
  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_rise_o |=> flag_q);

  // R10: a clear with no new match drops the flag
  assert_flag_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !match_rise_o) |=> !flag_q);

  // R10: the flag only falls when the host clears it
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CORR_W        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       irq_n
);

  localparam int CNT_W = $clog2(TICKS_PER_SEC + (1 << (CORR_W - 1)) + 1);

  rtc_time_t        now;
  rtc_time_t        alarm_t;
  rtc_time_t        shadow_q;
  logic             run_q, autocorr_q, irq_en_q;
  logic [7:0]       corr_lo_stage_q;
  logic [15:0]      corr_q;
  logic [7:0]       rdata_q;

  logic             in_field_range;
  logic             wr_time, wr_alarm, wr_ctrl, snap_req;
  logic             wr_corr_lo, wr_corr_hi, clr_flag;
  logic [15:0]      corr_candidate;
  logic             hour_mark;
  logic [CNT_W-1:0] reload;
  logic             sec_evt;
  logic             seconds_write;
  logic             match_rise;
  logic             flag;

  assign in_field_range = (addr[2:0] < 3'(NUM_FIELDS));
  assign wr_time        = wr_en && (addr[4:3] == 2'b00) && in_field_range;
  assign wr_alarm       = wr_en && (addr[4:3] == 2'b01) && in_field_range;
  assign wr_ctrl        = wr_en && (addr == A_CTRL);
  assign snap_req       = wr_ctrl && wdata[1];
  assign wr_corr_lo     = wr_en && (addr == A_CORR_L);
  assign wr_corr_hi     = wr_en && (addr == A_CORR_H);
  assign clr_flag       = wr_en && (addr == A_STATUS) && wdata[0];
  assign corr_candidate = {wdata, corr_lo_stage_q};
  assign seconds_write  = wr_time && (addr[2:0] == 3'd0);

  assign hour_mark = autocorr_q && (now.secs == 8'h00) && (now.mins == 8'h00);
  assign reload    = hour_mark ? CNT_W'(corrected_period(TICKS_PER_SEC, corr_q))
                               : CNT_W'(TICKS_PER_SEC);

  rtc_prescaler #(
    .TICKS (TICKS_PER_SEC),
    .CNT_W (CNT_W)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_en),
    .run_i     (run_q),
    .restart_i (seconds_write),
    .reload_i  (reload),
    .sec_evt_o (sec_evt)
  );

  rtc_calendar u_calendar (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_evt_i (sec_evt),
    .wr_i      (wr_time),
    .idx_i     (addr[2:0]),
    .wdata_i   (wdata),
    .now_o     (now)
  );

  rtc_alarm u_alarm (
    .clk          (clk),
    .rst_n        (rst_n),
    .now_i        (now),
    .wr_i         (wr_alarm),
    .idx_i        (addr[2:0]),
    .wdata_i      (wdata),
    .clr_i        (clr_flag),
    .irq_en_i     (irq_en_q),
    .alarm_o      (alarm_t),
    .match_rise_o (match_rise),
    .flag_o       (flag),
    .irq_n_o      (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q           <= 1'b0;
      autocorr_q      <= 1'b0;
      irq_en_q        <= 1'b0;
      corr_lo_stage_q <= 8'h00;
      corr_q          <= 16'h0000;
      shadow_q        <= TIME_AT_RESET;
    end else begin
      if (wr_ctrl) begin
        run_q      <= wdata[0];
        autocorr_q <= wdata[2];
      end
      if (snap_req) shadow_q <= now;
      if (wr_en && addr == A_IRQEN) irq_en_q <= wdata[0];
      if (wr_corr_lo) corr_lo_stage_q <= wdata;
      if (wr_corr_hi && corr_candidate != CORR_FORBIDDEN) corr_q <= corr_candidate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (rd_en) begin
      unique case (addr[4:3])
        2'b00:   rdata_q <= get_field(shadow_q, addr[2:0]);
        2'b01:   rdata_q <= get_field(alarm_t, addr[2:0]);
        2'b10: begin
          case (addr)
            A_CTRL:   rdata_q <= {5'd0, autocorr_q, 1'b0, run_q};
            A_STATUS: rdata_q <= {7'd0, flag};
            A_IRQEN:  rdata_q <= {7'd0, irq_en_q};
            A_CORR_L: rdata_q <= corr_q[7:0];
            A_CORR_H: rdata_q <= corr_q[15:8];
            default:  rdata_q <= 8'h00;
          endcase
        end
        default: rdata_q <= 8'h00;
      endcase
    end
  end

  assign rdata = rdata_q;

  // R3: a stopped clock only changes through host writes
  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_time) |=> $stable(now));

  // R6: the shadow captures the pre-edge live time
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (shadow_q == $past(now)));

  // R7: the forbidden correction code never lands
  assert_corr_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_corr_hi && corr_candidate == CORR_FORBIDDEN) |=> $stable(corr_q));

  // R8: the corrected reload is never empty
  assert_reload_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hour_mark |-> (reload != '0));

  // R9: the flag rise is tied to a match edge
  assert_match_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match_rise));

endmodule

// File: tb/rtc_bcd_core_tb.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb;

  localparam int TPS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] ctl_v = 8'h00;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    ctl_v = v; wr(5'h10, v);
  endtask

  // t = {yr,mon,day,hr,min,sec}; seconds written last restarts the prescaler
  task automatic set_time(input logic [47:0] t);
    for (int i = 5; i >= 0; i--) wr(5'(i), t[i*8 +: 8]);
  endtask

  task automatic read_shadow(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin rd(5'(i), b); t[i*8 +: 8] = b; end
  endtask

  task automatic get_time(output logic [47:0] t);
    wr(5'h10, ctl_v | 8'h02);
    read_shadow(t);
  endtask

  task automatic t_reset();
    logic [47:0] t; logic [7:0] b;
    read_shadow(t);
    chk("R1 reset time", t, 48'h00_01_01_00_00_00);
    rd(5'h10, b); chk("R1 reset control", 48'(b), 48'h00);
    rd(5'h11, b); chk("R1 reset status", 48'(b), 48'h00);
    chk("R1 reset irq_n", 48'(irq_n), 48'h1);
  endtask

  task automatic t_hold();
    logic [47:0] t;
    set_ctl(8'h00);
    set_time(48'h25_06_15_12_30_40);
    ticks(TPS * 3);
    get_time(t);
    chk("R3 stopped clock ignores ticks", t, 48'h25_06_15_12_30_40);
  endtask

  task automatic t_period();
    logic [47:0] t; logic [7:0] b;
    set_ctl(8'h01);
    set_time(48'h25_06_15_12_30_10);
    ticks(TPS - 1); get_time(t);
    chk("R4 one tick short of a second", t, 48'h25_06_15_12_30_10);
    ticks(1); get_time(t);
    chk("R4 full second", t, 48'h25_06_15_12_30_11);
    rd(5'h10, b); chk("R2 SNAP reads zero, RUN set", 48'(b), 48'h01);
  endtask

  task automatic roll(input string req, input logic [47:0] from, input logic [47:0] to);
    logic [47:0] t;
    set_time(from); ticks(TPS); get_time(t);
    chk(req, t, to);
  endtask

  task automatic t_rollover();
    set_ctl(8'h01);
    roll("R5 minute/hour carry", 48'h25_06_15_12_59_59, 48'h25_06_15_13_00_00);
    roll("R5 thirty-day month", 48'h25_04_30_23_59_59, 48'h25_05_01_00_00_00);
    roll("R5 leap February", 48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00);
    roll("R5 leap February end", 48'h24_02_29_23_59_59, 48'h24_03_01_00_00_00);
    roll("R5 plain February", 48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00);
    roll("R5 century wrap", 48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00);
  endtask

  task automatic t_snapshot();
    logic [47:0] t;
    set_ctl(8'h01);
    set_time(48'h30_07_04_10_20_30);
    wr(5'h10, 8'h03);
    ticks(TPS * 2);
    read_shadow(t);
    chk("R6 shadow frozen between snapshots", t, 48'h30_07_04_10_20_30);
    get_time(t);
    chk("R6 new snapshot", t, 48'h30_07_04_10_20_32);
  endtask

  task automatic t_corr_regs();
    logic [7:0] lo, hi;
    wr(5'h14, 8'h0A); rd(5'h14, lo);
    chk("R7 low byte only staged", 48'(lo), 48'h00);
    wr(5'h15, 8'h00); rd(5'h14, lo); rd(5'h15, hi);
    chk("R7 commit", 48'({hi, lo}), 48'h000A);
    wr(5'h14, 8'hFF); wr(5'h15, 8'h7F); rd(5'h14, lo); rd(5'h15, hi);
    chk("R7 0x7FFF ignored", 48'({hi, lo}), 48'h000A);
    wr(5'h14, 8'h00); wr(5'h15, 8'h80); rd(5'h14, lo); rd(5'h15, hi);
    chk("R7 most negative accepted", 48'({hi, lo}), 48'h8000);
  endtask

  // measures the second after 00->01 with the given correction and control
  task automatic corr_second(input string req, input logic [15:0] c,
                             input logic [7:0] ctl, input logic [7:0] mins);
    logic [47:0] t; int len;
    len = (ctl[2] && mins == 8'h00) ? TPS - int'($signed(c)) : TPS;
    wr(5'h14, c[7:0]); wr(5'h15, c[15:8]);
    set_ctl(ctl);
    set_time({40'h25_01_01_05_00 | 40'(mins), 8'h00});
    ticks(TPS); get_time(t);
    chk({req, " step 00->01"}, 48'(t[7:0]), 48'h01);
    ticks(len - 1); get_time(t);
    chk({req, " one tick early"}, 48'(t[7:0]), 48'h01);
    ticks(1); get_time(t);
    chk({req, " exact length"}, 48'(t[7:0]), 48'h02);
  endtask

  task automatic t_hourly();
    corr_second("R8 positive correction", 16'd10, 8'h05, 8'h00);
    corr_second("R8 negative correction", 16'hFFEC, 8'h05, 8'h00);
    corr_second("R8 correction disabled", 16'd10, 8'h01, 8'h00);
    corr_second("R8 not on the hour", 16'd10, 8'h05, 8'h01);
  endtask

  task automatic t_alarm();
    logic [7:0] b;
    set_ctl(8'h00);
    for (int i = 0; i < 6; i++) wr(5'(8 + i), 8'h00);
    wr(5'h08, 8'h05); wr(5'h0B, 8'h01); wr(5'h0C, 8'h01);
    rd(5'h08, b); chk("R2 alarm seconds readback", 48'(b), 48'h05);
    set_time(48'h00_01_01_00_00_04);
    wr(5'h12, 8'h01); wr(5'h11, 8'h01);
    rd(5'h11, b); chk("R10 flag cleared before test", 48'(b), 48'h00);
    set_ctl(8'h01);
    ticks(TPS - 1); @(negedge clk); @(negedge clk);
    chk("R11 irq_n high before match", 48'(irq_n), 48'h1);
    ticks(1); @(negedge clk); @(negedge clk);
    chk("R11 irq_n low after match", 48'(irq_n), 48'h0);
    rd(5'h11, b); chk("R9 flag set on match", 48'(b), 48'h01);
    set_ctl(8'h00);
    wr(5'h11, 8'h00); rd(5'h11, b);
    chk("R10 writing zero keeps flag", 48'(b), 48'h01);
    wr(5'h12, 8'h00); @(negedge clk);
    chk("R11 enable off releases irq_n", 48'(irq_n), 48'h1);
    wr(5'h11, 8'h01); rd(5'h11, b);
    chk("R10 write one clears", 48'(b), 48'h00);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hold();
    t_period();
    t_rollover();
    t_snapshot();
    t_corr_regs();
    t_hourly();
    t_alarm();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule